// File: doc/BRIEF.md
# Erasable Byte Memory with Identifier Readout

This block is a synthesizable behavioural model of an 8-bit-wide erasable programmable memory. It is meant to sit beside a programming controller in a testbench or an emulation build. Every cell starts at 1. Programming can only clear bits. A single erase command returns the whole array to the all-ones state.

Two active-low enables gate the output, so several copies can share one data bus. Two digital flags stand in for analog voltages. `vpp_hi` marks the high programming supply and selects program mode. `id_hv` marks the raised voltage on address bit 9 and selects identifier readout. In identifier mode the block returns fixed manufacturer and device bytes, and each of those bytes carries odd parity.

All results are registered. Output data, the output-enable flag and the error flag settle one clock after the inputs that cause them. The data output reads 0 whenever the output is not driven, which stands for high impedance.

Top module: `eprom_model`

## Requirements
- R1: `dout_en` is 1 one clock after a cycle in which `ce_n`=0, `oe_n`=0 and `vpp_hi`=0. In every other case `dout_en` is 0, `dout` is 8'h00 and `id_err` is 0. With `id_hv`=0 the driven value is the byte stored at `addr` modulo DEPTH.
- R2: While `ce_n`=1 (power-down) the outputs are undriven one clock later, whatever the value of `oe_n`.
- R3: After reset every byte reads 8'hFF, and the outputs are undriven.
- R4: A cycle with `erase`=1 sets every byte to 8'hFF at the next edge. A program strobe in that same cycle is dropped.
- R5: A program strobe stores old AND `din` at `addr`, so no 0 bit ever returns to 1 through programming. A strobe is a cycle with `vpp_hi`=1 and `ce_n`=0 whose previous cycle had `ce_n`=1.
- R6: No write happens while `ce_n` is held high with `vpp_hi`=1 (inhibit). No write happens in later cycles of a held-low `ce_n`. No write happens while `vpp_hi`=0.
- R7: Locations can be programmed in any address order, and each keeps its own value.
- R8: With `id_hv`=1 in a read cycle, `addr[0]`=0 returns 8'h97 and `addr[0]`=1 returns 8'h85, when all address bits other than 0 and 9 are 0.
- R9: Both identifier bytes have odd parity over all 8 bits, with bit 7 acting as the parity bit.
- R10: In identifier mode, any 1 on an address bit other than 0 and 9 sets `id_err`=1 and returns 8'hFF.
- R11: While `vpp_hi`=1 the outputs are undriven one clock later, even with both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also erases the array |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| ce_n | input | 1 | Active-low chip enable; high means power-down or program inhibit |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply present (selects program mode) |
| id_hv | input | 1 | Raised identifier voltage on address bit 9 |
| erase | input | 1 | One-cycle bulk erase command |
| dout | output | 8 | Read data, 0 when undriven |
| dout_en | output | 1 | Output driven (0 means high impedance) |
| id_err | output | 1 | Identifier access with stray address bits set |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. A program or erase applied in one cycle becomes visible through a read in the following cycle. The bench drives each cycle's inputs at the falling edge and pushes the expected result into a queue at the same moment. A monitor pops the queue 5 ns after the next rising edge and compares the item against the ports, so every comparison lands on the cycle in which the registered result appears. Expected data comes from a reference copy of the array kept by the bench. That copy applies the AND-programming, strobe and erase rules given in the requirements.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    // Identifier payloads without their parity bit; bit 7 is computed.
    localparam logic [6:0] MFG_PAYLOAD = 7'h17;
    localparam logic [6:0] DEV_PAYLOAD = 7'h05;

    // Address bits with a fixed meaning in identifier mode.
    localparam int ID_SEL_BIT = 0;
    localparam int ID_HV_BIT  = 9;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OUTDIS,
        MD_PROG,
        MD_INHIBIT,
        MD_IDENT
    } mode_e;

    typedef struct packed {
        logic [7:0] data;
        logic       drive;
        logic       err;
        logic       ce_prev;
    } out_state_t;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    output mode_e             mode,
    output logic              id_sel,
    output logic              id_bad
);
    logic [ADDR_W-1:0] stray_mask;

    // Every address bit except the selector and the high-voltage bit.
    always_comb begin
        stray_mask = '1;
        stray_mask[ID_SEL_BIT] = 1'b0;
        if (ADDR_W > ID_HV_BIT) begin
            stray_mask[ID_HV_BIT % ADDR_W] = 1'b0;
        end
    end

    always_comb begin
        if (vpp_hi) begin
            mode = ce_n ? MD_INHIBIT : MD_PROG;
        end else if (ce_n) begin
            mode = MD_STANDBY;
        end else if (oe_n) begin
            mode = MD_OUTDIS;
        end else if (id_hv) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
    end

    assign id_sel = addr[ID_SEL_BIT];
    assign id_bad = |(addr & stray_mask);
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
    import eprom_pkg::*;
(
    input  logic       sel,
    input  logic       bad,
    output logic [7:0] id_byte
);
    logic [6:0] payload;

    always_comb begin
        payload = sel ? DEV_PAYLOAD : MFG_PAYLOAD;
        if (bad) begin
            id_byte = 8'hFF;
        end else begin
            // Bit 7 is chosen so that the byte has an odd number of ones.
            id_byte = {~^payload, payload};
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] cells [DEPTH];

    assign rdata = cells[idx];

    // Reset and erase both return the array to the all-ones state.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              erase,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              id_err
);
    localparam int IDX_W = $clog2(DEPTH);

    mode_e      mode;
    logic       id_sel;
    logic       id_bad;
    logic [7:0] id_byte;
    logic [7:0] rdata;
    logic       wr_stb;
    out_state_t st_d;
    out_state_t st_q;

    eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .addr   (addr),
        .mode   (mode),
        .id_sel (id_sel),
        .id_bad (id_bad)
    );

    eprom_id_rom u_id (
        .sel     (id_sel),
        .bad     (id_bad),
        .id_byte (id_byte)
    );

    eprom_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .wr_en (wr_stb),
        .idx   (addr[IDX_W-1:0]),
        .wdata (din),
        .rdata (rdata)
    );

    // A program strobe is the first low cycle of a chip-enable pulse.
    assign wr_stb = (mode == MD_PROG) && st_q.ce_prev && !erase;

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_n;
        st_d.drive   = 1'b0;
        st_d.data    = 8'h00;
        st_d.err     = 1'b0;
        case (mode)
            MD_READ: begin
                st_d.drive = 1'b1;
                st_d.data  = rdata;
            end
            MD_IDENT: begin
                st_d.drive = 1'b1;
                st_d.data  = id_byte;
                st_d.err   = id_bad;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{data: 8'h00, drive: 1'b0, err: 1'b0, ce_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.data;
    assign dout_en = st_q.drive;
    assign id_err  = st_q.err;
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              id_err
);
    assert_drive_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n && !vpp_hi));

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00 && !id_err));

    assert_powerdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en);

    assert_id_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(id_hv) && !id_err) |-> ($countones(dout) % 2 == 1));

    assert_id_err_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> (dout_en && dout == 8'hFF && $past(addr[ADDR_W-1:1] != '0)));

    assert_prog_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vpp_hi) |-> !dout_en);
endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .dout    (dout),
    .dout_en (dout_en),
    .id_err  (id_err)
);

// File: tb/eprom_model_tb.sv
module eprom_model_tb;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 1024;

    typedef struct {
        logic       en;
        logic [7:0] d;
        logic       err;
        string      req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = 8'h00;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              vpp_hi = 1'b0;
    logic              id_hv = 1'b0;
    logic              erase = 1'b0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              id_err;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t sb[$];

    logic [7:0] ref_mem [DEPTH];
    logic       ref_ce_prev = 1'b1;

    always #10 clk = ~clk;

    eprom_model #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .id_hv   (id_hv),
        .erase   (erase),
        .dout    (dout),
        .dout_en (dout_en),
        .id_err  (id_err)
    );

    task automatic check(input logic en, input logic [7:0] d, input logic err, input string req);
        total++;
        if (dout_en !== en || dout !== d || id_err !== err) begin
            bad++;
            $display("FAIL %s: got en=%0b dout=%02h err=%0b, expected en=%0b dout=%02h err=%0b",
                     req, dout_en, dout, id_err, en, d, err);
        end
    endtask

    // Driver: apply one cycle of inputs, predict the registered result.
    task automatic step(input logic c, input logic o, input logic v, input logic h,
                        input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input logic er, input string req);
        exp_t e;
        int   ix;
        logic [ADDR_W-1:0] stray;
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hi = v; id_hv = h; addr = a; din = d; erase = er;
        ix = int'(a) % DEPTH;
        e.req = req;
        e.en = 1'b0; e.d = 8'h00; e.err = 1'b0;
        if (!c && !o && !v) begin
            e.en = 1'b1;
            if (h) begin
                stray = a & ~16'h0201;
                e.err = (stray != '0);
                e.d = e.err ? 8'hFF : (a[0] ? 8'h85 : 8'h97);
            end else begin
                e.d = ref_mem[ix];
            end
        end
        sb.push_back(e);
        if (er) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        end else if (v && !c && ref_ce_prev) begin
            ref_mem[ix] = ref_mem[ix] & d;
        end
        ref_ce_prev = c;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string req);
        step(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b0, req);
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
        step(1'b1, 1'b1, 1'b1, 1'b0, a, d, 1'b0, req);
        step(1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b0, req);
        step(1'b1, 1'b1, 1'b1, 1'b0, a, d, 1'b0, req);
    endtask

    // Monitor: compare each prediction just after the edge that registers it.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.en, e.d, e.err, e.req);
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 8'h00, 1'b0, "R3 reset outputs");

        // R3: erased contents after reset
        rd(16'd0, "R3");
        rd(16'd5, "R3");
        rd(16'd1023, "R3");

        // R1 / R2: enable gating
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, "R1 oe high");
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, "R2 powerdown oe low");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, "R2 powerdown oe high");

        // R6 inhibit, then R5 program, R6 held low with new data
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'd5, 8'h00, 1'b0, "R6 inhibit");
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'd5, 8'h00, 1'b0, "R6 inhibit");
        rd(16'd5, "R6 inhibit left FF");
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'd5, 8'hA5, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'd5, 8'h00, 1'b0, "R6 R11 held low");
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'd5, 8'h00, 1'b0, "R6");
        rd(16'd5, "R5 R6 programmed A5");

        // R5: AND behaviour, no bit set back
        prog(16'd5, 8'h5A, "R5");
        rd(16'd5, "R5 and to 00");
        prog(16'd5, 8'hFF, "R5");
        rd(16'd5, "R5 no set");

        // R7: out-of-order programming
        prog(16'd1023, 8'h3C, "R7");
        prog(16'd3, 8'hC3, "R7");
        prog(16'd700, 8'h81, "R7");
        rd(16'd700, "R7");
        rd(16'd3, "R7");
        rd(16'd1023, "R7");
        rd(16'd4, "R7 neighbour");

        // R6: chip-enable pulses without programming supply do not write
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'd9, 8'h00, 1'b0, "R6 no vpp");
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'd9, 8'h00, 1'b0, "R6 no vpp");
        rd(16'd9, "R6 no vpp");

        // R11: program mode with both enables low
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'd3, 8'hC3, 1'b0, "R11");

        // R8 / R9 / R10: identifier mode
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b0, "R8 R9 mfg");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 8'h00, 1'b0, "R8 R9 dev");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b0, "R8 bit9 low");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0202, 8'h00, 1'b0, "R10 stray bit1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h8201, 8'h00, 1'b0, "R10 stray bit15");
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0201, 8'h00, 1'b0, "R1 id oe high");

        // R4: erase wins over a same-cycle program strobe
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'd700, 8'h00, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'd700, 8'h00, 1'b1, "R4 erase");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'd700, 8'h00, 1'b0, "R4");
        rd(16'd700, "R4");
        rd(16'd5, "R4");
        rd(16'd1023, "R4");
        rd(16'd3, "R4");

        step(1'b1, 1'b1, 1'b0, 1'b0, 16'd0, 8'h00, 1'b0, "R2 end");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule